// File: doc/BRIEF.md
# Audio Clock Ratio Speed Detector

This block watches the three clocks of an audio serial stream (master clock, frame clock and bit clock) from a free-running reference clock. It counts master clock cycles over each frame and matches the count against the ratios a converter accepts. From that it picks one of three sampling speed modes: normal, double or quad. It reports the speed mode, the oversampling rate for that mode and a flag that says whether the latest frame gave an accepted ratio.

A control input selects automatic operation, where the speed follows the measured ratio, or manual operation, where a 2-bit speed code sets it. The block also raises a power-save flag when every audio clock has gone quiet. After reset the flag stays up until all three clocks have toggled. It drops again by itself once all three clocks are seen again.

The reference clock must run more than twice as fast as the master clock. All three audio clocks enter through two-flop synchronisers.

Top module: `clk_ratio_detect`

## Requirements
- R1: While reset is held and right after it, speed is 00 (normal), osr is 128, ratio_ok is 0 and psave is 1.
- R2: With auto_sel = 0, speed follows man_spd in the same cycle: code 00 gives 00 (normal), 01 gives 01 (double), 10 gives 10 (quad), and the reserved code 11 gives 00 (normal).
- R3: With auto_sel = 1, speed is derived from the measured master clocks per frame. A ratio of 512, 768 or 1152 gives 00. A ratio of 256 or 384 gives 01. A ratio of 128 or 192 gives 10.
- R4: osr is 128 when speed is 00, 64 when speed is 01 and 32 when speed is 10.
- R5: A frame count within ±2 of a nominal ratio is accepted. Such a frame sets ratio_ok at the clock edge that sees the frame clock rise which closes it.
- R6: A frame count that is not within ±2 of any nominal ratio clears ratio_ok and leaves the automatic speed unchanged.
- R7: The automatic speed changes only when two consecutive complete frames match the same nominal ratio.
- R8: With auto_sel = 0, ratio_ok is set only if the matched ratio is permitted for the manual speed. Normal permits 256, 384, 512, 768 and 1152. Double permits 128, 192, 256 and 384. Quad permits 128 and 192.
- R9: After 4096 reference cycles with no edge on any audio clock, psave goes to 1 and ratio_ok to 0. The automatic speed is kept.
- R10: psave returns to 0 only after edges have been seen on all three audio clocks. Activity on only some of them keeps psave at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Audio master clock (asynchronous) |
| lrck | input | 1 | Audio frame clock (asynchronous) |
| bick | input | 1 | Audio bit clock (asynchronous) |
| auto_sel | input | 1 | 1 = automatic speed detection, 0 = manual |
| man_spd | input | 2 | Manual speed code |
| speed | output | 2 | Selected speed: 00 normal, 01 double, 10 quad |
| osr | output | 8 | Oversampling rate of the selected speed |
| ratio_ok | output | 1 | Last complete frame gave an accepted ratio |
| psave | output | 1 | Audio clocks absent; power-save requested |

## Verification
The stream generator sweeps every nominal ratio in turn: 512, 256, 128, 192, 384, 768 and 1152. This shows that each ratio lands in its own speed class and that the change waits for a second matching frame. Off-nominal frames are then used. A count two cycles from nominal must still be accepted. A count far from every nominal must clear the valid flag and freeze the mode. Manual codes, including the reserved one, are applied against both permitted and forbidden ratios. Finally the clocks are stopped completely, and then restarted one at a time. This separates the idle timeout from the recovery, which needs all three clocks.

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect #(
  parameter int CNT_W   = 12,
  parameter int TIMEOUT = 4096,
  parameter int TOL     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk,
  input  logic       lrck,
  input  logic       bick,
  input  logic       auto_sel,
  input  logic [1:0] man_spd,
  output logic [1:0] speed,
  output logic [7:0] osr,
  output logic       ratio_ok,
  output logic       psave
);

  localparam int IDLE_W = $clog2(TIMEOUT + 1);
  localparam int NOM [7] = '{128, 192, 256, 384, 512, 768, 1152};

  function automatic logic [2:0] ratio_idx(input logic [CNT_W-1:0] c);
    ratio_idx = 3'd0;
    for (int i = 0; i < 7; i++)
      if (int'(c) >= NOM[i] - TOL && int'(c) <= NOM[i] + TOL) ratio_idx = 3'(i + 1);
  endfunction

  function automatic logic [1:0] idx_speed(input logic [2:0] i);
    case (i)
      3'd1, 3'd2: idx_speed = 2'd2;
      3'd3, 3'd4: idx_speed = 2'd1;
      default:    idx_speed = 2'd0;
    endcase
  endfunction

  function automatic logic idx_allowed(input logic [2:0] i, input logic [1:0] s);
    case (s)
      2'd1:    idx_allowed = (i >= 3'd1) && (i <= 3'd4);
      2'd2:    idx_allowed = (i == 3'd1) || (i == 3'd2);
      default: idx_allowed = (i >= 3'd3);
    endcase
  endfunction

  logic [2:0]        m_s, l_s, b_s;
  logic [CNT_W-1:0]  cnt;
  logic [IDLE_W-1:0] idle;
  logic [2:0]        seen;
  logic [2:0]        prev_idx;
  logic              armed;
  logic [1:0]        auto_spd;

  wire              m_rise  = m_s[1] & ~m_s[2];
  wire              lr_rise = l_s[1] & ~l_s[2];
  wire [2:0]        edges   = {b_s[1] ^ b_s[2], l_s[1] ^ l_s[2], m_s[1] ^ m_s[2]};
  wire              any_edge = |edges;
  wire              tmo_hit = ~any_edge && (idle == IDLE_W'(TIMEOUT - 1));
  wire              active  = &seen;
  wire [CNT_W-1:0]  meas    = (&cnt) ? cnt : cnt + CNT_W'(m_rise);
  wire [2:0]        idx     = ratio_idx(meas);
  wire [1:0]        man_eff = (man_spd == 2'b11) ? 2'b00 : man_spd;

  assign speed = auto_sel ? auto_spd : man_eff;
  assign osr   = 8'd128 >> speed;
  assign psave = ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s <= '0;
      l_s <= '0;
      b_s <= '0;
    end else begin
      m_s <= {m_s[1:0], mclk};
      l_s <= {l_s[1:0], lrck};
      b_s <= {b_s[1:0], bick};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle <= '0;
      seen <= '0;
    end else begin
      if (any_edge) idle <= '0;
      else if (idle != IDLE_W'(TIMEOUT)) idle <= idle + 1'b1;
      if (tmo_hit) seen <= '0;
      else seen <= seen | edges;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      armed    <= 1'b0;
      ratio_ok <= 1'b0;
      prev_idx <= '0;
      auto_spd <= 2'd0;
    end else if (!active || tmo_hit) begin
      cnt      <= '0;
      armed    <= 1'b0;
      ratio_ok <= 1'b0;
      prev_idx <= '0;
    end else if (lr_rise) begin
      if (armed) begin
        ratio_ok <= auto_sel ? (idx != 3'd0) : idx_allowed(idx, man_eff);
        if (idx != 3'd0 && idx == prev_idx) auto_spd <= idx_speed(idx);
        prev_idx <= idx;
      end
      armed <= 1'b1;
      cnt   <= '0;
    end else begin
      cnt <= meas;
    end
  end

  AST_RESERVED_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_sel && man_spd == 2'b11) |-> (osr == 8'd128)); // R2
  AST_SPEED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    speed != 2'b11); // R3
  AST_OK_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_ok) |-> $past(lr_rise)); // R5
  AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    !lr_rise |=> $stable(auto_spd)); // R7
  AST_PSAVE_NO_OK: assert property (@(posedge clk) disable iff (!rst_n)
    psave |-> !ratio_ok); // R9
  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idle <= IDLE_W'(TIMEOUT)); // R9
  AST_WAKE_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psave) |-> $past(edges != 3'b000)); // R10

endmodule

// File: tb/clk_ratio_detect_tb_top.sv
module clk_ratio_detect_tb_top;
  localparam int TMO = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0, mclk = 1'b0, lrck = 1'b0, bick = 1'b0, auto_sel = 1'b1;
  logic [1:0] man_spd = 2'b00;
  logic [1:0] speed;
  logic [7:0] osr;
  logic ratio_ok, psave;

  clk_ratio_detect dut_i (
    .clk(clk), .rst_n(rst_n), .mclk(mclk), .lrck(lrck), .bick(bick),
    .auto_sel(auto_sel), .man_spd(man_spd),
    .speed(speed), .osr(osr), .ratio_ok(ratio_ok), .psave(psave));

  always #5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // stimulus controls, consumed at the falling edge
  bit nx_rst = 0, nx_auto = 1, m_on = 0, l_on = 0, b_on = 0;
  logic [1:0] nx_man = 2'b00;
  int ratio = 512;
  int ph = 0;

  // behavioural reference state
  bit hm[$], hl[$], hb[$];
  int r_cnt, r_idle, r_prev, r_aspd;
  bit r_armed, r_ok, r_sm, r_sl, r_sb;
  int noms[$] = '{128, 192, 256, 384, 512, 768, 1152};

  function automatic int nearest(int c);
    nearest = 0;
    foreach (noms[k]) if (c - noms[k] <= 2 && noms[k] - c <= 2) nearest = noms[k];
  endfunction

  function automatic int spd_of(int n);
    if (n >= 512) return 0;
    if (n >= 256) return 1;
    return 2;
  endfunction

  function automatic bit perm(int n, int s);
    if (n == 0) return 0;
    if (s == 2) return n <= 192;
    if (s == 1) return n <= 384;
    return n >= 256;
  endfunction

  task automatic model_reset();
    hm = '{0, 0, 0}; hl = '{0, 0, 0}; hb = '{0, 0, 0};
    r_cnt = 0; r_idle = 0; r_prev = 0; r_aspd = 0;
    r_armed = 0; r_ok = 0; r_sm = 0; r_sl = 0; r_sb = 0;
  endtask

  task automatic model_step();
    bit mr, lr, em, el, eb, any_e, hit, act;
    int meas, n, ms;
    if (!rst_n) begin model_reset(); return; end
    mr = hm[1] && !hm[2]; lr = hl[1] && !hl[2];
    em = hm[1] != hm[2]; el = hl[1] != hl[2]; eb = hb[1] != hb[2];
    any_e = em || el || eb;
    hit = !any_e && (r_idle == TMO - 1);
    act = r_sm && r_sl && r_sb;
    meas = (r_cnt == 4095) ? r_cnt : r_cnt + int'(mr);
    ms = (man_spd == 2'b11) ? 0 : int'(man_spd);
    if (!act || hit) begin
      r_armed = 0; r_ok = 0; r_prev = 0; r_cnt = 0;
    end else if (lr) begin
      if (r_armed) begin
        n = nearest(meas);
        r_ok = auto_sel ? (n != 0) : perm(n, ms);
        if (n != 0 && n == r_prev) r_aspd = spd_of(n);
        r_prev = n;
      end
      r_armed = 1; r_cnt = 0;
    end else r_cnt = meas;
    if (any_e) r_idle = 0; else if (r_idle != TMO) r_idle++;
    if (hit) begin r_sm = 0; r_sl = 0; r_sb = 0; end
    else begin r_sm |= em; r_sl |= el; r_sb |= eb; end
    hm.push_front(mclk); void'(hm.pop_back());
    hl.push_front(lrck); void'(hl.pop_back());
    hb.push_front(bick); void'(hb.pop_back());
  endtask

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int es, bp, mc;
    if (!done) begin
      model_step();
      es = auto_sel ? r_aspd : ((man_spd == 2'b11) ? 0 : int'(man_spd));
      check("R2 R3 R7 speed", int'(speed), es);
      check("R4 osr", int'(osr), 128 >> es);
      check("R5 R6 R8 ratio_ok", int'(ratio_ok), int'(r_ok));
      check("R9 R10 psave", int'(psave), int'(!(r_sm && r_sl && r_sb)));
    end
    rst_n = nx_rst; auto_sel = nx_auto; man_spd = nx_man;
    ph++;
    mc = ph / 4;
    bp = (ratio / 16 < 2) ? 2 : ratio / 16;
    if (m_on) mclk = (ph % 4) < 2;
    if (l_on) lrck = (mc % ratio) < ratio / 2;
    if (b_on) bick = (ph % bp) < bp / 2;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_ratio(int r, int frames);
    ratio = r;
    wait_cyc(frames * r * 4);
  endtask

  initial begin
    model_reset();
    wait_cyc(5);
    check("R1 speed", int'(speed), 0);
    check("R1 osr", int'(osr), 128);
    check("R1 ratio_ok", int'(ratio_ok), 0);
    check("R1 psave", int'(psave), 1);
    nx_rst = 1;
    wait_cyc(3);
    check("R1 psave after release", int'(psave), 1);
    m_on = 1; l_on = 1; b_on = 1;
    run_ratio(512, 4);
    check("R3 512 speed", int'(speed), 0);
    check("R5 512 ok", int'(ratio_ok), 1);
    check("R10 psave clear", int'(psave), 0);
    run_ratio(256, 4);
    check("R3 256 speed", int'(speed), 1);
    check("R4 double osr", int'(osr), 64);
    run_ratio(128, 4);
    check("R3 128 speed", int'(speed), 2);
    check("R4 quad osr", int'(osr), 32);
    run_ratio(192, 4);
    check("R3 192 speed", int'(speed), 2);
    run_ratio(384, 4);
    check("R3 384 speed", int'(speed), 1);
    run_ratio(768, 4);
    check("R3 768 speed", int'(speed), 0);
    run_ratio(1152, 3);
    check("R3 1152 speed", int'(speed), 0);
    run_ratio(130, 4);
    check("R5 130 near 128 speed", int'(speed), 2);
    check("R5 130 ok", int'(ratio_ok), 1);
    run_ratio(300, 4);
    check("R6 300 ok cleared", int'(ratio_ok), 0);
    check("R6 300 speed held", int'(speed), 2);
    nx_auto = 0; nx_man = 2'b01;
    wait_cyc(2);
    check("R2 manual 01", int'(speed), 1);
    nx_man = 2'b11;
    wait_cyc(2);
    check("R2 manual 11 reserved", int'(speed), 0);
    nx_man = 2'b10;
    run_ratio(128, 4);
    check("R8 quad 128 ok", int'(ratio_ok), 1);
    check("R2 manual 10", int'(speed), 2);
    run_ratio(512, 4);
    check("R8 quad 512 rejected", int'(ratio_ok), 0);
    nx_man = 2'b00;
    run_ratio(512, 3);
    check("R8 normal 512 ok", int'(ratio_ok), 1);
    nx_auto = 1;
    wait_cyc(2);
    check("R3 auto tracked 512", int'(speed), 0);
    m_on = 0; l_on = 0; b_on = 0;
    wait_cyc(3500);
    check("R9 before timeout", int'(psave), 0);
    wait_cyc(800);
    check("R9 psave set", int'(psave), 1);
    check("R9 ok cleared", int'(ratio_ok), 0);
    check("R9 speed kept", int'(speed), 0);
    m_on = 1;
    wait_cyc(400);
    check("R10 mclk only", int'(psave), 1);
    b_on = 1;
    wait_cyc(400);
    check("R10 two clocks", int'(psave), 1);
    l_on = 1; ratio = 128;
    wait_cyc(1200);
    check("R10 all clocks", int'(psave), 0);
    wait_cyc(2000);
    check("R3 after wake", int'(speed), 2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule